// File: doc/BRIEF.md
# Three-Port Parallel I/O Controller

This block attaches to a CPU bus and provides three 8-bit parallel ports, called A, B and C. Port C is split into two 4-bit halves, and each half has its own direction. The CPU reads and writes the ports and an internal control register through a small bus interface. That interface has an 8-bit data bus (split into data-in, data-out and an output enable), active-low chip select, read and write strobes, and a 2-bit register select.

A control register write does one of two things, chosen by its top bit:

- **Mode word.** Sets the direction of A, B and the two halves of C, and clears every output latch.
- **Single-bit command.** Sets or clears one bit of the port C output latch and leaves everything else unchanged.

Ports A and B capture their input pins on every clock edge. Port C input pins reach the read path directly, with no register. A port configured as an output drives its latch onto its pins and raises its pin enables. Mode-field values that would request handshake or bidirectional operation are stored, but they act as plain I/O.

A write is taken on each rising clock edge during which chip select and write are both low. A write held for several cycles therefore repeats, which is harmless because every write is idempotent. Read data is combinational while chip select and read are both low.

Top module: `tri_port_pio`

## Requirements
- R1: While `rst` is high and after it falls, the control register holds 0x9B. All port enables (`pa_oe`, `pb_oe`, `pc_oe`) are low and all output latches are zero.
- R2: Register select encoding: 00 selects port A, 01 port B, 10 port C, 11 the control register. Reading select 11 returns the stored control word.
- R3: A write takes effect only on a clock edge where `cs_n` and `wr_n` are both low. Otherwise no latch, direction or control value changes.
- R4: `bus_oe` is high only while `cs_n` and `rd_n` are both low, and `bus_dout` is zero whenever `bus_oe` is low.
- R5: A control write with bit 7 = 1 is a mode word. Bit 4 sets port A direction, bit 1 port B, bit 3 the upper half of port C and bit 0 the lower half, with 1 meaning input. A port's enables are high exactly when it is an output. Bits 6:5 and 2 are stored and readable but have no effect.
- R6: A mode word write clears the output latches of ports A, B and C to zero on the same clock edge.
- R7: A control write with bit 7 = 0 loads bit 0 into port C output bit number `bus_din[3:1]`. The other port C bits, all directions and the stored control word are unchanged.
- R8: A write to port A, B or C loads its output latch on that clock edge, whatever the port's direction. The latch appears on `pa_out`/`pb_out`/`pc_out`.
- R9: Reading a port configured as output returns its output latch value.
- R10: Reading port A or B configured as input returns the pin value captured at the most recent rising clock edge.
- R11: Reading port C returns, per half, the live `pc_in` pins if that half is an input, or the output latch if it is an output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| sel | input | 2 | Register select (A, B, C, control) |
| bus_din | input | 8 | Write data from CPU |
| bus_dout | output | 8 | Read data to CPU |
| bus_oe | output | 1 | Drive enable for the CPU data bus |
| pa_in | input | 8 | Port A pins in |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A driving (output mode) |
| pb_in | input | 8 | Port B pins in |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B driving (output mode) |
| pc_in | input | 8 | Port C pins in |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-bit drive enables (one value per half) |

## Verification
The bench targets the corner cases where a plausible design goes wrong:

- **Command decode.** A single-bit command must not be taken for a mode word. If it were, it would clear every latch and rewrite the directions.
- **Mixed port C.** With one half input and one half output, a design that muxes the whole port from one direction bit returns pins where the latch belongs, or the reverse.
- **Input capture timing.** Port A input is checked in the cycle right after a pin change. A design without the input register would show the new value one cycle early.
- **Rejected strobes.** Writes with chip select high, and reads with only one strobe low, are checked. A decoder that ignores either signal would corrupt registers or drive the bus.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int DW    = 8;
  localparam int HW    = DW / 2;
  localparam int IDX_W = $clog2(DW);

  typedef enum logic [1:0] {
    SEL_A    = 2'b00,
    SEL_B    = 2'b01,
    SEL_C    = 2'b10,
    SEL_CTRL = 2'b11
  } sel_e;

  localparam logic [DW-1:0] CTRL_RESET = 8'h9B;

  // control word bit positions
  localparam int B_MODE   = 7;
  localparam int B_DIR_A  = 4;
  localparam int B_DIR_CH = 3;
  localparam int B_DIR_B  = 1;
  localparam int B_DIR_CL = 0;

  typedef struct packed {
    logic a_in;
    logic b_in;
    logic ch_in;
    logic cl_in;
  } dir_t;
endpackage

// File: rtl/pio_bus_decode.sv
module pio_bus_decode
  import pio_pkg::*;
(
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] sel,
  output logic [3:0] wr_hit,
  output logic       rd_act
);
  logic wr_act;

  always_comb begin
    wr_act = !cs_n && !wr_n;
    rd_act = !cs_n && !rd_n;
    wr_hit = '0;
    if (wr_act) wr_hit[sel] = 1'b1;
  end
endmodule

// File: rtl/pio_ctrl_reg.sv
module pio_ctrl_reg
  import pio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctrl,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    ctrl_q,
  output dir_t             dir,
  output logic             mode_load,
  output logic             bsr_load,
  output logic [IDX_W-1:0] bsr_idx,
  output logic             bsr_val
);
  always_comb begin
    mode_load = wr_ctrl && din[B_MODE];
    bsr_load  = wr_ctrl && !din[B_MODE];
    bsr_idx   = din[IDX_W:1];
    bsr_val   = din[0];
  end

  always_ff @(posedge clk) begin
    if (rst)            ctrl_q <= CTRL_RESET;
    else if (mode_load) ctrl_q <= din;
  end

  always_comb begin
    dir.a_in  = ctrl_q[B_DIR_A];
    dir.b_in  = ctrl_q[B_DIR_B];
    dir.ch_in = ctrl_q[B_DIR_CH];
    dir.cl_in = ctrl_q[B_DIR_CL];
  end
endmodule

// File: rtl/pio_port.sv
module pio_port #(
  parameter int W        = 8,
  parameter bit IN_LATCH = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         wr,
  input  logic [W-1:0] din,
  input  logic         is_input,
  input  logic [W-1:0] pins,
  output logic [W-1:0] out_q,
  output logic         oe,
  output logic [W-1:0] rd_val
);
  logic [W-1:0] in_q;

  always_ff @(posedge clk) begin
    if (rst || clear) out_q <= '0;
    else if (wr)      out_q <= din;
  end

  generate
    if (IN_LATCH) begin : g_in_reg
      always_ff @(posedge clk) begin
        if (rst) in_q <= '0;
        else     in_q <= pins;
      end
    end else begin : g_in_pass
      assign in_q = pins;
    end
  endgenerate

  assign oe     = !is_input;
  assign rd_val = is_input ? in_q : out_q;
endmodule

// File: rtl/pio_portc_half.sv
module pio_portc_half
  import pio_pkg::*;
#(
  parameter int W  = HW,
  parameter bit HI = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             wr,
  input  logic [W-1:0]     din,
  input  logic             bsr_load,
  input  logic [IDX_W-1:0] bsr_idx,
  input  logic             bsr_val,
  input  logic             is_input,
  input  logic [W-1:0]     pins,
  output logic [W-1:0]     out_q,
  output logic [W-1:0]     oe,
  output logic [W-1:0]     rd_val
);
  localparam int NB_W = $clog2(W);

  logic            bsr_hit;
  logic [NB_W-1:0] bit_no;

  always_comb begin
    bsr_hit = bsr_load && (bsr_idx[IDX_W-1] == HI);
    bit_no  = bsr_idx[NB_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clear)  out_q <= '0;
    else if (wr)       out_q <= din;
    else if (bsr_hit)  out_q[bit_no] <= bsr_val;
  end

  assign oe     = {W{!is_input}};
  assign rd_val = is_input ? pins : out_q;
endmodule

// File: rtl/pio_read_mux.sv
module pio_read_mux
  import pio_pkg::*;
(
  input  logic          rd_act,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] rd_a,
  input  logic [DW-1:0] rd_b,
  input  logic [DW-1:0] rd_c,
  input  logic [DW-1:0] ctrl,
  output logic [DW-1:0] dout,
  output logic          oe
);
  always_comb begin
    dout = '0;
    oe   = rd_act;
    if (rd_act) begin
      case (sel)
        SEL_A:   dout = rd_a;
        SEL_B:   dout = rd_b;
        SEL_C:   dout = rd_c;
        default: dout = ctrl;
      endcase
    end
  end
endmodule

// File: rtl/tri_port_pio.sv
module tri_port_pio
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic          pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic          pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe
);
  logic [3:0]       wr_hit;
  logic             rd_act;
  logic [DW-1:0]    ctrl_q;
  dir_t             dir;
  logic             mode_load, bsr_load, bsr_val;
  logic [IDX_W-1:0] bsr_idx;
  logic [DW-1:0]    rd_a, rd_b, rd_c;

  pio_bus_decode u_dec (
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .sel(sel),
    .wr_hit(wr_hit), .rd_act(rd_act)
  );

  pio_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_hit[SEL_CTRL]), .din(bus_din),
    .ctrl_q(ctrl_q), .dir(dir), .mode_load(mode_load), .bsr_load(bsr_load),
    .bsr_idx(bsr_idx), .bsr_val(bsr_val)
  );

  pio_port #(.W(DW), .IN_LATCH(1'b1)) u_pa (
    .clk(clk), .rst(rst), .clear(mode_load), .wr(wr_hit[SEL_A]), .din(bus_din),
    .is_input(dir.a_in), .pins(pa_in), .out_q(pa_out), .oe(pa_oe), .rd_val(rd_a)
  );

  pio_port #(.W(DW), .IN_LATCH(1'b1)) u_pb (
    .clk(clk), .rst(rst), .clear(mode_load), .wr(wr_hit[SEL_B]), .din(bus_din),
    .is_input(dir.b_in), .pins(pb_in), .out_q(pb_out), .oe(pb_oe), .rd_val(rd_b)
  );

  generate
    for (genvar h = 0; h < 2; h++) begin : g_pc
      logic half_in;
      assign half_in = (h == 1) ? dir.ch_in : dir.cl_in;
      pio_portc_half #(.W(HW), .HI(h == 1)) u_half (
        .clk(clk), .rst(rst), .clear(mode_load), .wr(wr_hit[SEL_C]),
        .din(bus_din[h*HW +: HW]), .bsr_load(bsr_load), .bsr_idx(bsr_idx),
        .bsr_val(bsr_val), .is_input(half_in), .pins(pc_in[h*HW +: HW]),
        .out_q(pc_out[h*HW +: HW]), .oe(pc_oe[h*HW +: HW]),
        .rd_val(rd_c[h*HW +: HW])
      );
    end
  endgenerate

  pio_read_mux u_rmux (
    .rd_act(rd_act), .sel(sel), .rd_a(rd_a), .rd_b(rd_b), .rd_c(rd_c),
    .ctrl(ctrl_q), .dout(bus_dout), .oe(bus_oe)
  );
endmodule

// File: rtl/tri_port_pio_chk.sv
module tri_port_pio_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic [1:0] sel,
  input logic [7:0] bus_din,
  input logic [7:0] bus_dout,
  input logic       bus_oe,
  input logic [7:0] pa_out,
  input logic       pa_oe,
  input logic [7:0] pb_out,
  input logic       pb_oe,
  input logic [7:0] pc_out,
  input logic [7:0] pc_oe
);
  logic wr_ok, mode_wr, cmd_wr;
  assign wr_ok   = !cs_n && !wr_n;
  assign mode_wr = wr_ok && (sel == 2'b11) && bus_din[7];
  assign cmd_wr  = wr_ok && (sel == 2'b11) && !bus_din[7];

  p_reset_dirs_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pa_oe && !pb_oe && pc_oe == 8'h00 &&
                    pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

  p_idle_stable_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_ok |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
                $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

  p_oe_read_only_r4: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> (!cs_n && !rd_n));

  p_quiet_bus_r4: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> (bus_dout == 8'h00));

  p_mode_dirs_r5: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (pa_oe == !$past(bus_din[4]) && pb_oe == !$past(bus_din[1]) &&
                 pc_oe == {{4{!$past(bus_din[3])}}, {4{!$past(bus_din[0])}}}));

  p_mode_clears_r6: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

  p_cmd_one_bit_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> ($countones(pc_out ^ $past(pc_out)) <= 1 &&
                pc_out[$past(bus_din[3:1])] == $past(bus_din[0]) &&
                $stable(pc_oe) && $stable(pa_oe) && $stable(pb_oe)));

  p_port_a_load_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && sel == 2'b00) |=> (pa_out == $past(bus_din)));
endmodule

bind tri_port_pio tri_port_pio_chk chk_i (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .sel(sel),
  .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
  .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
  .pc_out(pc_out), .pc_oe(pc_oe)
);

// File: tb/tri_port_pio_tb_top.sv
module tri_port_pio_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] sel = 2'b00;
  logic [7:0] bus_din = 8'h00;
  logic [7:0] bus_dout;
  logic       bus_oe;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pb_out, pc_out, pc_oe;
  logic       pa_oe, pb_oe;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  tri_port_pio dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .sel(sel),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  // vector: [22] 1=read 0=write, [21:20] sel, [19:12] write data or pin value,
  //         [11:4] expected read data, [3:0] requirement number
  localparam int NV = 28;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 2'd3, 8'h00, 8'h9B, 4'd1},   // R1 control after reset
    {1'b1, 2'd0, 8'h5A, 8'h5A, 4'd10},  // R10 A input
    {1'b1, 2'd1, 8'h5A, 8'h5A, 4'd10},  // R10 B input
    {1'b1, 2'd2, 8'h5A, 8'h5A, 4'd11},  // R11 C input both halves
    {1'b0, 2'd3, 8'h80, 8'h00, 4'd5},   // R5 all outputs
    {1'b1, 2'd0, 8'h5A, 8'h00, 4'd6},   // R6 latch cleared
    {1'b0, 2'd0, 8'h3C, 8'h00, 4'd8},   // R8
    {1'b1, 2'd0, 8'h77, 8'h3C, 4'd9},   // R9 pins ignored
    {1'b0, 2'd1, 8'hC3, 8'h00, 4'd8},
    {1'b1, 2'd1, 8'h11, 8'hC3, 4'd9},
    {1'b0, 2'd2, 8'h96, 8'h00, 4'd8},
    {1'b1, 2'd2, 8'hFF, 8'h96, 4'd9},
    {1'b0, 2'd3, 8'h02, 8'h00, 4'd7},   // R7 clear bit 1
    {1'b1, 2'd2, 8'h00, 8'h94, 4'd7},
    {1'b0, 2'd3, 8'h07, 8'h00, 4'd7},   // R7 set bit 3
    {1'b1, 2'd2, 8'h00, 8'h9C, 4'd7},
    {1'b1, 2'd3, 8'h00, 8'h80, 4'd7},   // R7 mode kept
    {1'b0, 2'd3, 8'h88, 8'h00, 4'd5},   // C upper in
    {1'b1, 2'd2, 8'hA5, 8'hA0, 4'd11},  // R11 mixed halves
    {1'b1, 2'd0, 8'hA5, 8'h00, 4'd6},
    {1'b0, 2'd3, 8'hE5, 8'h00, 4'd5},   // spare bits set, C lower in
    {1'b1, 2'd2, 8'h5A, 8'h0A, 4'd11},
    {1'b1, 2'd1, 8'h5A, 8'h00, 4'd5},
    {1'b1, 2'd3, 8'h00, 8'hE5, 4'd2},   // R2 control readback
    {1'b0, 2'd3, 8'h92, 8'h00, 4'd5},
    {1'b1, 2'd0, 8'h33, 8'h33, 4'd10},
    {1'b1, 2'd1, 8'h33, 8'h33, 4'd2},
    {1'b1, 2'd2, 8'h33, 8'h00, 4'd11}
  };

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] s, input logic [7:0] d,
                           input logic csn, input logic wrn);
    @(negedge clk);
    sel = s; bus_din = d; cs_n = csn; wr_n = wrn;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_read(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk);
    sel = s; cs_n = 1'b0; rd_n = 1'b0;
    #1 v = bus_dout;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk);
    pa_in = v; pb_in = v; pc_in = v;
    @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(posedge clk);
    #1;
    // R1 state during reset
    check8("R1 pa_oe", {7'd0, pa_oe}, 8'h00);
    check8("R1 pc_oe", pc_oe, 8'h00);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check8("R1 pb_oe", {7'd0, pb_oe}, 8'h00);
    check8("R1 pa_out", pa_out, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      if (v[22]) begin
        set_pins(v[19:12]);
        bus_read(v[21:20], r);
        check8($sformatf("R%0d vector %0d", v[3:0], i), r, v[11:4]);
      end else begin
        bus_write(v[21:20], v[19:12], 1'b0, 1'b0);
      end
    end

    // R3: writes without both strobes low are dropped (control is 0x92 here)
    bus_write(2'd3, 8'h80, 1'b1, 1'b0);
    bus_write(2'd3, 8'h80, 1'b0, 1'b1);
    bus_read(2'd3, r);
    check8("R3 control unchanged", r, 8'h92);
    bus_write(2'd2, 8'hFF, 1'b1, 1'b0);
    check8("R3 pc_out unchanged", pc_out, 8'h00);

    // R4: bus enable only with chip select and read both low
    @(negedge clk); sel = 2'd3; cs_n = 1'b0; rd_n = 1'b1;
    #1 check8("R4 no rd", {7'd0, bus_oe}, 8'h00);
    check8("R4 dout quiet", bus_dout, 8'h00);
    cs_n = 1'b1; rd_n = 1'b0;
    #1 check8("R4 no cs", {7'd0, bus_oe}, 8'h00);
    cs_n = 1'b0;
    #1 check8("R4 valid read", {7'd0, bus_oe}, 8'h01);
    cs_n = 1'b1; rd_n = 1'b1;

    // R5: pin enables follow direction bits
    bus_write(2'd3, 8'h88, 1'b0, 1'b0);
    check8("R5 pa_oe", {7'd0, pa_oe}, 8'h01);
    check8("R5 pb_oe", {7'd0, pb_oe}, 8'h01);
    check8("R5 pc_oe", pc_oe, 8'h0F);
    bus_write(2'd3, 8'h91, 1'b0, 1'b0);
    check8("R5 pa_oe in", {7'd0, pa_oe}, 8'h00);
    check8("R5 pc_oe split", pc_oe, 8'hF0);

    // R8: latch loads even when the port is an input
    bus_write(2'd0, 8'h5A, 1'b0, 1'b0);
    check8("R8 pa_out input dir", pa_out, 8'h5A);
    bus_write(2'd3, 8'h80, 1'b0, 1'b0);
    check8("R6 pa_out cleared", pa_out, 8'h00);

    // R7: command sets bit 7 only
    bus_write(2'd3, 8'h0F, 1'b0, 1'b0);
    check8("R7 bit7 set", pc_out, 8'h80);
    check8("R7 pc_oe kept", pc_oe, 8'hFF);

    // R1: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check8("R1 pc_out after reset", pc_out, 8'h00);
    check8("R1 pc_oe after reset", pc_oe, 8'h00);
    bus_read(2'd3, r);
    check8("R1 control after reset", r, 8'h9B);

    // R10 / R11: A input is registered, C input is not
    set_pins(8'h11);
    @(negedge clk);
    pa_in = 8'hC7; pc_in = 8'hC7;
    sel = 2'd0; cs_n = 1'b0; rd_n = 1'b0;
    #1 check8("R10 A holds captured value", bus_dout, 8'h11);
    sel = 2'd2;
    #1 check8("R11 C live pins", bus_dout, 8'hC7);
    cs_n = 1'b1; rd_n = 1'b1;
    bus_read(2'd0, r);
    check8("R10 A after edge", r, 8'hC7);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule